// File: doc/BRIEF.md
# Dual-Width Read-Only Memory Pin Interface

This block models the pin side of a read-only memory that a single mode input switches between two organisations: 16-bit halfwords reached by a 21-bit address, or 8-bit bytes reached by a 22-bit address. One pin changes role with the mode. In halfword mode it carries the top data bit out of the block. In byte mode it carries the lowest byte-address bit into the block. The stored contents come from an arithmetic function of the halfword index, so no file or memory initialisation is needed.

The array read is registered: the address, mode and shared-pin bit are captured on a rising clock edge and the selected data appears on the data pins after that edge. The pad enables are combinational from the present chip-enable, output-enable and mode inputs. Each data pin has its own enable output for a pad ring outside the block. A build-time parameter sets how output enable is decoded: active low, active high, or not used at all.

Top module: `rom_dual_width_if`

## Requirements
- R1: With `word_mode_i` high, the halfword at index `addr_i` appears one clock edge after it is presented: bits 14..0 on `data_o` and bit 15 on `shared_o`.
- R2: With `word_mode_i` low, the byte address is `{addr_i, shared_i}` with `shared_i` as bit 0; the halfword at index `addr_i` is read and its low byte (bits 7..0) is shown when `shared_i` is 0, its high byte (bits 15..8) when `shared_i` is 1. The byte is on `data_o[7:0]` one clock edge later.
- R3: In byte mode `data_oe_o[14:8]` stay low, while `data_oe_o[7:0]` follow the enable decode.
- R4: In byte mode `shared_oe_o` is low in every cycle.
- R5: While `ce_n_i` is high, `data_oe_o` is all zeros and `shared_oe_o` is low, whatever the other inputs are.
- R6: With `OE_MODE` = 0, output enable is active low: `oe_i` high forces all pad enables low.
- R7: With `OE_MODE` = 1, output enable is active high: `oe_i` low forces all pad enables low.
- R8: With `OE_MODE` = 2, `oe_i` has no effect and the enables depend only on `ce_n_i` and the mode.
- R9: The halfword at index a holds low byte `a[7:0] ^ 8'h3C` and high byte `a[15:8] ^ {3'b000, a[20:16]} ^ 8'hC3`.
- R10: While `rst_n` is low the read register holds zero, so an enabled halfword read shows `data_o` = 0 and `shared_o` = 0.
- R11: The two bytes read in byte mode at byte addresses 2h and 2h+1 equal the low and high halves of the halfword read in halfword mode at index h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the registered array read |
| rst_n | input | 1 | Active-low reset of the read register |
| word_mode_i | input | 1 | High selects halfword organisation, low selects byte organisation |
| ce_n_i | input | 1 | Active-low chip enable |
| oe_i | input | 1 | Output enable, decoded as set by `OE_MODE` |
| addr_i | input | 21 | Halfword index, or upper bits of the byte address |
| shared_i | input | 1 | Value on the shared pin, used as byte-address bit 0 in byte mode |
| data_o | output | 15 | Data bits 14..0 |
| data_oe_o | output | 15 | Per-pin drive enable for `data_o` |
| shared_o | output | 1 | Data bit 15 for the shared pin in halfword mode |
| shared_oe_o | output | 1 | Drive enable for the shared pin |

## Verification
The assertions assume the mode input is only changed while the shared pin has been released by both sides. They also assume it is held for at least one edge before a read result is used, because the data path lags the enable path by one cycle. The stimulus sets mode, address and shared bit on the falling edge, lets one rising edge pass, and samples on the next falling edge. It never samples a result whose address was set under a different mode. The enable checks change only `ce_n_i` and `oe_i` between samples, so data from the register stays valid while the enables are being observed.

// File: rtl/rom_dw_pkg.sv
package rom_dw_pkg;

    // Output-enable decode choices
    localparam int OE_ACT_LOW  = 0;
    localparam int OE_ACT_HIGH = 1;
    localparam int OE_UNUSED   = 2;

endpackage

// File: rtl/rom_cell_array.sv
module rom_cell_array #(
    parameter int ADDR_W = 21,
    parameter int BYTE_W = 8,
    parameter logic [BYTE_W-1:0] LO_MASK = 8'h3C,
    parameter logic [BYTE_W-1:0] HI_MASK = 8'hC3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  word_mode_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic                  shared_i,
    output logic [2*BYTE_W-1:0]   half_q_o,
    output logic                  lsb_q_o,
    output logic                  word_q_o
);
    localparam int HW_W = 2 * BYTE_W;

    typedef struct packed {
        logic [HW_W-1:0] half;
        logic            lsb;
        logic            word;
    } rd_st_t;

    rd_st_t rd_d, rd_q;

    // Arithmetic contents: one halfword per index
    function automatic logic [HW_W-1:0] cell_value(input logic [ADDR_W-1:0] a);
        logic [BYTE_W-1:0] lo_b, hi_b, top_b;
        top_b = BYTE_W'(a >> HW_W);
        lo_b  = a[BYTE_W-1:0] ^ LO_MASK;
        hi_b  = a[HW_W-1:BYTE_W] ^ top_b ^ HI_MASK;
        return {hi_b, lo_b};
    endfunction

    always_comb begin
        rd_d      = rd_q;
        rd_d.half = cell_value(addr_i);
        rd_d.lsb  = word_mode_i ? 1'b0 : shared_i;
        rd_d.word = word_mode_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign half_q_o = rd_q.half;
    assign lsb_q_o  = rd_q.lsb;
    assign word_q_o = rd_q.word;

    // R2: the byte select is only meaningful in byte mode
    p_lsb_idle_in_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
        word_q_o |-> !lsb_q_o);

    // R10: register starts cleared
    p_reset_clear_r10: assert property (@(posedge clk)
        !rst_n |=> (half_q_o == '0) || !$past(!rst_n));

endmodule

// File: rtl/rom_lane_steer.sv
module rom_lane_steer #(
    parameter int BYTE_W = 8
) (
    input  logic [2*BYTE_W-1:0] half_i,
    input  logic                lsb_i,
    input  logic                word_i,
    output logic [2*BYTE_W-2:0] pins_o,
    output logic                top_o
);
    localparam int HW_W  = 2 * BYTE_W;
    localparam int PIN_N = HW_W - 1;

    genvar gi;
    generate
        for (gi = 0; gi < PIN_N; gi++) begin : g_pin
            if (gi < BYTE_W) begin : g_low
                // low lane carries either half in byte mode
                assign pins_o[gi] = word_i ? half_i[gi]
                                  : (lsb_i ? half_i[gi+BYTE_W] : half_i[gi]);
            end else begin : g_high
                assign pins_o[gi] = word_i ? half_i[gi] : 1'b0;
            end
        end
    endgenerate

    assign top_o = word_i ? half_i[HW_W-1] : 1'b0;

endmodule

// File: rtl/rom_pad_ctl.sv
module rom_pad_ctl
    import rom_dw_pkg::*;
#(
    parameter int OE_MODE = OE_ACT_LOW
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n_i,
    input  logic oe_i,
    input  logic word_mode_i,
    output logic lo_oe_o,
    output logic hi_oe_o,
    output logic shared_oe_o
);
    logic oe_ok;

    generate
        if (OE_MODE == OE_ACT_LOW) begin : g_oe_low
            assign oe_ok = ~oe_i;
        end else if (OE_MODE == OE_ACT_HIGH) begin : g_oe_high
            assign oe_ok = oe_i;
        end else begin : g_oe_none
            logic unused_oe;
            assign unused_oe = oe_i;
            assign oe_ok     = 1'b1;
        end
    endgenerate

    logic en;
    assign en          = ~ce_n_i & oe_ok;
    assign lo_oe_o     = en;
    assign hi_oe_o     = en & word_mode_i;
    assign shared_oe_o = en & word_mode_i;

    // R4: shared pin stays an input in byte mode
    p_shared_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !word_mode_i |-> !shared_oe_o);

    // R5: deselected chip drives nothing
    p_ce_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n_i |-> !(lo_oe_o || hi_oe_o || shared_oe_o));

    // R3: upper lane never without lower lane
    p_upper_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hi_oe_o |-> lo_oe_o);

endmodule

// File: rtl/rom_dual_width_if.sv
module rom_dual_width_if
    import rom_dw_pkg::*;
#(
    parameter int ADDR_W  = 21,
    parameter int BYTE_W  = 8,
    parameter int OE_MODE = OE_ACT_LOW
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  word_mode_i,
    input  logic                  ce_n_i,
    input  logic                  oe_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic                  shared_i,
    output logic [2*BYTE_W-2:0]   data_o,
    output logic [2*BYTE_W-2:0]   data_oe_o,
    output logic                  shared_o,
    output logic                  shared_oe_o
);
    localparam int HW_W = 2 * BYTE_W;

    logic [HW_W-1:0] half_q;
    logic            lsb_q;
    logic            word_q;
    logic            lo_oe, hi_oe;

    rom_cell_array #(
        .ADDR_W (ADDR_W),
        .BYTE_W (BYTE_W)
    ) u_array (
        .clk         (clk),
        .rst_n       (rst_n),
        .word_mode_i (word_mode_i),
        .addr_i      (addr_i),
        .shared_i    (shared_i),
        .half_q_o    (half_q),
        .lsb_q_o     (lsb_q),
        .word_q_o    (word_q)
    );

    rom_lane_steer #(
        .BYTE_W (BYTE_W)
    ) u_steer (
        .half_i (half_q),
        .lsb_i  (lsb_q),
        .word_i (word_q),
        .pins_o (data_o),
        .top_o  (shared_o)
    );

    rom_pad_ctl #(
        .OE_MODE (OE_MODE)
    ) u_pads (
        .clk         (clk),
        .rst_n       (rst_n),
        .ce_n_i      (ce_n_i),
        .oe_i        (oe_i),
        .word_mode_i (word_mode_i),
        .lo_oe_o     (lo_oe),
        .hi_oe_o     (hi_oe),
        .shared_oe_o (shared_oe_o)
    );

    assign data_oe_o = {{(BYTE_W-1){hi_oe}}, {BYTE_W{lo_oe}}};

    // R1: shared pin only drives alongside the full data bus
    p_shared_with_bus_r1: assert property (@(posedge clk) disable iff (!rst_n)
        shared_oe_o |-> (&data_oe_o));

    // R3: in byte mode the upper data pins are released
    p_upper_off_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !word_mode_i |-> (data_oe_o[HW_W-2:BYTE_W] == '0));

    // R5: enables are all-or-nothing within the low lane
    p_low_lane_uniform_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_oe_o[BYTE_W-1:0] == '0) || (&data_oe_o[BYTE_W-1:0]));

endmodule

// File: tb/rom_dual_width_if_tb_top.sv
module rom_dual_width_if_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        word_mode = 1'b1;
    logic        ce_n = 1'b0;
    logic        oe = 1'b0;
    logic [20:0] addr = '0;
    logic        shared_in = 1'b0;

    logic [14:0] d0, oe0, d1, oe1, d2, oe2;
    logic        s0, so0, s1, so1, s2, so2;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rom_dual_width_if #(.OE_MODE(0)) dut_i (
        .clk(clk), .rst_n(rst_n), .word_mode_i(word_mode), .ce_n_i(ce_n),
        .oe_i(oe), .addr_i(addr), .shared_i(shared_in),
        .data_o(d0), .data_oe_o(oe0), .shared_o(s0), .shared_oe_o(so0));

    rom_dual_width_if #(.OE_MODE(1)) dut_ah_i (
        .clk(clk), .rst_n(rst_n), .word_mode_i(word_mode), .ce_n_i(ce_n),
        .oe_i(oe), .addr_i(addr), .shared_i(shared_in),
        .data_o(d1), .data_oe_o(oe1), .shared_o(s1), .shared_oe_o(so1));

    rom_dual_width_if #(.OE_MODE(2)) dut_ig_i (
        .clk(clk), .rst_n(rst_n), .word_mode_i(word_mode), .ce_n_i(ce_n),
        .oe_i(oe), .addr_i(addr), .shared_i(shared_in),
        .data_o(d2), .data_oe_o(oe2), .shared_o(s2), .shared_oe_o(so2));

    function automatic logic [15:0] exp_half(input logic [20:0] a);
        logic [7:0] lo, hi;
        lo = a[7:0] ^ 8'h3C;
        hi = a[15:8] ^ {3'b000, a[20:16]} ^ 8'hC3;
        return {hi, lo};
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic rd_word(input logic [20:0] a, output logic [15:0] got);
        @(negedge clk);
        word_mode = 1'b1; addr = a; shared_in = 1'b0;
        @(negedge clk);
        got = {s0, d0};
    endtask

    task automatic rd_byte(input logic [21:0] b, output logic [7:0] got);
        @(negedge clk);
        word_mode = 1'b0; addr = b[21:1]; shared_in = b[0];
        @(negedge clk);
        got = d0[7:0];
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] w;
        logic [7:0]  bl, bh;
        // R10: reset state with an enabled halfword read
        repeat (3) @(negedge clk);
        chk(d0 == 15'h0 && s0 == 1'b0, "R10 reset data", {s0, d0}, 0);
        chk(oe0 == 15'h7FFF && so0, "R10 enables during reset", {so0, oe0}, 16'hFFFF);
        rst_n = 1'b1;

        // R1 R9: halfword sweep
        for (int i = 0; i < 300; i++) begin
            logic [20:0] a;
            a = (i == 0) ? 21'h0 : (i == 1) ? 21'h1FFFFF : 21'((i * 40503 + i * i * 7) & 32'h1FFFFF);
            rd_word(a, w);
            chk(w == exp_half(a), "R1 R9 halfword data", w, exp_half(a));
            chk(oe0 == 15'h7FFF && so0 == 1'b1, "R1 halfword enables", {so0, oe0}, 16'hFFFF);
        end

        // R2 R3 R4 R9: byte sweep
        for (int i = 0; i < 300; i++) begin
            logic [21:0] b;
            logic [15:0] h;
            b = (i == 0) ? 22'h0 : (i == 1) ? 22'h3FFFFF : 22'((i * 104729 + i) & 32'h3FFFFF);
            rd_byte(b, bl);
            h = exp_half(b[21:1]);
            chk(bl == (b[0] ? h[15:8] : h[7:0]), "R2 R9 byte data", bl, b[0] ? h[15:8] : h[7:0]);
            chk(oe0 == 15'h00FF, "R3 byte upper pins released", oe0, 15'h00FF);
            chk(so0 == 1'b0, "R4 shared pin not driven", so0, 0);
        end

        // R11: both organisations agree
        for (int i = 0; i < 64; i++) begin
            logic [20:0] h;
            h = 21'((i * 32771 + 5) & 32'h1FFFFF);
            rd_word(h, w);
            rd_byte({h, 1'b0}, bl);
            rd_byte({h, 1'b1}, bh);
            chk({bh, bl} == w, "R11 byte pair equals halfword", {bh, bl}, w);
        end

        // R5 R6 R7 R8: enable decode in both modes
        for (int m = 0; m < 2; m++) begin
            @(negedge clk);
            word_mode = m[0]; addr = 21'h12345; shared_in = 1'b0;
            @(negedge clk);
            ce_n = 1'b0; oe = 1'b1; #1;
            chk(oe0 == 0 && so0 == 0, "R6 active-low oe deasserted", {so0, oe0}, 0);
            chk(oe1[0] == 1'b1, "R7 active-high oe asserted", oe1[0], 1);
            chk(oe2[0] == 1'b1, "R8 ignored oe high", oe2[0], 1);
            oe = 1'b0; #1;
            chk(oe0[0] == 1'b1, "R6 active-low oe asserted", oe0[0], 1);
            chk(oe1 == 0 && so1 == 0, "R7 active-high oe deasserted", {so1, oe1}, 0);
            chk(oe2[0] == 1'b1 && so2 == m[0], "R8 ignored oe low", {so2, oe2[0]}, {m[0], 1'b1});
            chk(d2 == d0, "R8 ignored oe same data", d2, d0);
            ce_n = 1'b1;
            for (int o = 0; o < 2; o++) begin
                oe = o[0]; #1;
                chk(oe0 == 0 && so0 == 0 && oe1 == 0 && so1 == 0 && oe2 == 0 && so2 == 0,
                    "R5 chip disabled", {oe0 | oe1 | oe2}, 0);
            end
            ce_n = 1'b0; oe = 1'b0;
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule